// File: doc/BRIEF.md
# Local Bus Target Cycle Responder

This block is the card-side front end of a target on a 486-style processor local bus, for example a graphics controller. It watches the processor address and cycle-type lines, claims the cycles that fall into its two windows through an active-low claim line, and ends each claimed cycle with an active-low ready pulse. The first window is a small I/O register window. The second is a memory read window with more wait states, standing for an expansion ROM.

Two strap inputs from the board change the timing of ready. One tells the target whether zero-wait writes are allowed. The other tells it that the bus clock is above 33 MHz, and in that case ROM reads get one more wait state. A configuration input chooses whether the address is decoded at the clock edge that samples the address strobe or at the edge after it.

On reads, the target enables its data drivers no later than the clock in which ready is low. It keeps them enabled until the board's return-ready input is sampled active. Writes are handed to the internal register file through a one-clock write port. The register file itself is not part of this block.

Top module: `lbt_target`

## Requirements
- R1: `claim_n` is a combinational function of `addr`, `mio` and `wr` alone, with no dependence on the clock, reset or `ads_n`. It is low exactly for an I/O cycle (`mio`=0) whose address lies in [REG_BASE, REG_BASE+2^REG_SPAN_BITS-1] (defaults 0x3C0..0x3CF), and for a memory read (`mio`=1, `wr`=0) whose address lies in [ROM_BASE, ROM_BASE+2^ROM_SPAN_BITS-1] (defaults 0xC0000..0xC7FFF). A memory cycle to 0x3C0 is not claimed, and neither is a memory write.
- R2: A claimed read never gets ready in the first T2 clock. The first T2 clock is the clock that follows the rising edge at which `ads_n` was sampled low.
- R3: When `fast_wr_ok`=0, `lrdy_n` stays high during the first T2 clock of a claimed write. When `fast_wr_ok`=1, a claimed register write with early decode and zero waits gets ready in that first T2 clock.
- R4: For a claimed cycle whose `ads_n` is sampled at edge E0, `lrdy_n` is low in the clock after edge E0+D. D = max(L + W, M), where L = `late_dec`, W = REG_WAIT for the register window or ROM_WAIT + `hi_speed` for the ROM window, and M = 1 for reads or when `fast_wr_ok`=0, otherwise 0.
- R5: `hi_speed` adds its extra wait state only to ROM-window reads. Register-window timing does not depend on it.
- R6: When `late_dec`=1, the address and cycle type are decoded at edge E0+1 rather than E0, which makes the cycle one clock longer as given by R4.
- R7: `lrdy_n` is low for exactly one clock per claimed cycle.
- R8: For a claimed read, `dout_en` rises at edge E0+1: never in the first T2 clock, and never later than the ready clock. While `dout_en` is high, `dout` equals `rd_data`; otherwise `dout` is zero.
- R9: Once raised, `dout_en` stays high until `rdyrtn_n` is sampled low at an edge no earlier than the end of the ready clock. It falls in the clock right after that edge.
- R10: For a claimed write, `wr_en` is high for the one clock after the ready clock. In that clock `wr_addr` is the cycle address and `wr_data` is the `wdata` value that was present during the ready clock.
- R11: An unclaimed cycle produces no ready, no `dout_en` and no `wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ads_n | input | 1 | Address strobe, active low, marks T1 |
| addr | input | AW | Processor address |
| mio | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| wr | input | 1 | 1 = write, 0 = read |
| fast_wr_ok | input | 1 | Board strap: 1 allows zero-wait writes |
| hi_speed | input | 1 | Board strap: 1 means bus clock above 33 MHz |
| late_dec | input | 1 | Configuration: 1 decodes one clock after the strobe |
| rdyrtn_n | input | 1 | Return-ready from the board, active low |
| wdata | input | DW | Write data from the bus |
| rd_data | input | DW | Read data from the internal register file |
| claim_n | output | 1 | Combinational cycle claim, active low |
| lrdy_n | output | 1 | Local ready, active low, one clock |
| dout | output | DW | Read data toward the bus drivers |
| dout_en | output | 1 | Read data driver enable |
| wr_en | output | 1 | Internal write strobe |
| wr_addr | output | AW | Address latched for the cycle |
| wr_data | output | DW | Write data latched in the ready clock |

## Verification
A wait counter that is off by one moves the single low clock of `lrdy_n`, and this is visible at the ports within the same cycle. Every combination of window, direction and strap is swept, and the bench predicts the exact ready clock for each one, so a counter error shows as a wrong sample. A state machine that returns to idle too early drops `dout_en` before return-ready arrives, or drops it late after it arrives. Return-ready is pulsed at two different offsets so that either fault changes the enable one clock away from its expected edge. A decode error shows up immediately on `claim_n`, without any clock edge, at the boundary addresses on both sides of each window.

// File: rtl/lbt_pkg.sv
package lbt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DEC  = 3'd1,
    ST_WAIT = 3'd2,
    ST_ACK  = 3'd3,
    ST_HOLD = 3'd4
  } lbt_state_e;

endpackage

// File: rtl/lbt_window.sv
module lbt_window #(
  parameter int unsigned    AW        = 20,
  parameter logic [AW-1:0]  BASE      = '0,
  parameter int unsigned    SPAN_BITS = 4
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  // aligned window: compare only the bits above the span
  always_comb begin
    hit = (addr[AW-1:SPAN_BITS] == BASE[AW-1:SPAN_BITS]);
  end
endmodule

// File: rtl/lbt_delay.sv
module lbt_delay #(
  parameter int unsigned REG_WAIT = 0,
  parameter int unsigned ROM_WAIT = 2,
  parameter int unsigned CW       = 4
) (
  input  logic          is_rom,
  input  logic          is_rd,
  input  logic          hi_speed,
  input  logic          fast_wr_ok,
  input  logic          late,
  output logic [CW-1:0] dly
);
  logic [CW-1:0] waits;
  logic [CW-1:0] raw;
  logic [CW-1:0] floor_v;

  always_comb begin
    if (is_rom) waits = CW'(ROM_WAIT) + CW'(hi_speed);
    else        waits = CW'(REG_WAIT);
    raw     = waits + CW'(late);
    // first T2 belongs to the board for reads, and for writes when straps forbid it
    floor_v = (is_rd || !fast_wr_ok) ? CW'(1) : CW'(0);
    dly     = (raw < floor_v) ? floor_v : raw;
  end
endmodule

// File: rtl/lbt_target.sv
module lbt_target #(
  parameter int unsigned    AW            = 20,
  parameter int unsigned    DW            = 16,
  parameter logic [AW-1:0]  REG_BASE      = 20'h003C0,
  parameter int unsigned    REG_SPAN_BITS = 4,
  parameter logic [AW-1:0]  ROM_BASE      = 20'hC0000,
  parameter int unsigned    ROM_SPAN_BITS = 15,
  parameter int unsigned    REG_WAIT      = 0,
  parameter int unsigned    ROM_WAIT      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ads_n,
  input  logic [AW-1:0] addr,
  input  logic          mio,
  input  logic          wr,
  input  logic          fast_wr_ok,
  input  logic          hi_speed,
  input  logic          late_dec,
  input  logic          rdyrtn_n,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] rd_data,
  output logic          claim_n,
  output logic          lrdy_n,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  import lbt_pkg::*;

  localparam int unsigned MAXW = (REG_WAIT > ROM_WAIT) ? REG_WAIT : ROM_WAIT;
  localparam int unsigned CW   = $clog2(MAXW + 4) + 1;

  // reset: asynchronous assert, synchronous release
  logic rst_s1_n, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_n <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      rst_s1_n <= 1'b1;
      rst_q_n  <= rst_s1_n;
    end
  end

  // window decode, purely combinational
  logic reg_hit, rom_hit, hit_reg_io, hit_rom_rd, claim;

  lbt_window #(.AW(AW), .BASE(REG_BASE), .SPAN_BITS(REG_SPAN_BITS)) u_win_reg (
    .addr (addr),
    .hit  (reg_hit)
  );
  lbt_window #(.AW(AW), .BASE(ROM_BASE), .SPAN_BITS(ROM_SPAN_BITS)) u_win_rom (
    .addr (addr),
    .hit  (rom_hit)
  );

  always_comb begin
    hit_reg_io = reg_hit && !mio;
    hit_rom_rd = rom_hit && mio && !wr;
    claim      = hit_reg_io || hit_rom_rd;
    claim_n    = !claim;
  end

  // state
  lbt_state_e     st, st_nxt;
  logic [CW-1:0]  cnt, cnt_nxt;
  logic           cyc_wr, cyc_wr_nxt;
  logic [AW-1:0]  cyc_addr, cyc_addr_nxt;
  logic           lrdy_n_nxt, dout_en_nxt, wr_en_nxt;
  logic           wdat_ce;
  logic [CW-1:0]  dly, rem;
  logic           in_dec, decode_now;

  assign in_dec = (st == ST_DEC);

  lbt_delay #(.REG_WAIT(REG_WAIT), .ROM_WAIT(ROM_WAIT), .CW(CW)) u_delay (
    .is_rom     (hit_rom_rd),
    .is_rd      (!wr),
    .hi_speed   (hi_speed),
    .fast_wr_ok (fast_wr_ok),
    .late       (in_dec),
    .dly        (dly)
  );

  always_comb begin
    st_nxt       = st;
    cnt_nxt      = cnt;
    cyc_wr_nxt   = cyc_wr;
    cyc_addr_nxt = cyc_addr;
    decode_now   = 1'b0;
    // one clock of the delay is already spent when decoding late
    rem          = in_dec ? (dly - CW'(1)) : dly;

    case (st)
      ST_IDLE: begin
        if (!ads_n) begin
          if (late_dec) st_nxt = ST_DEC;
          else          decode_now = 1'b1;
        end
      end
      ST_DEC:  decode_now = 1'b1;
      ST_WAIT: begin
        if (cnt == '0) st_nxt = ST_ACK;
        else           cnt_nxt = cnt - CW'(1);
      end
      ST_ACK: begin
        if (cyc_wr || !rdyrtn_n) st_nxt = ST_IDLE;
        else                     st_nxt = ST_HOLD;
      end
      ST_HOLD: begin
        if (!rdyrtn_n) st_nxt = ST_IDLE;
      end
      default: st_nxt = ST_IDLE;
    endcase

    if (decode_now) begin
      if (claim) begin
        cyc_wr_nxt   = wr;
        cyc_addr_nxt = addr;
        if (rem == '0) begin
          st_nxt = ST_ACK;
        end else begin
          st_nxt  = ST_WAIT;
          cnt_nxt = rem - CW'(1);
        end
      end else begin
        st_nxt = ST_IDLE;
      end
    end

    lrdy_n_nxt  = (st_nxt != ST_ACK);
    // drivers stay off in the first T2 clock: only raised when leaving a non-idle state
    dout_en_nxt = (st != ST_IDLE) && !cyc_wr_nxt &&
                  ((st_nxt == ST_WAIT) || (st_nxt == ST_ACK) || (st_nxt == ST_HOLD));
    wr_en_nxt   = (st == ST_ACK) && cyc_wr;
    wdat_ce     = (st == ST_ACK) && cyc_wr;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      cyc_wr   <= 1'b0;
      cyc_addr <= '0;
      lrdy_n   <= 1'b1;
      dout_en  <= 1'b0;
      wr_en    <= 1'b0;
      wr_data  <= '0;
    end else begin
      st       <= st_nxt;
      cnt      <= cnt_nxt;
      cyc_wr   <= cyc_wr_nxt;
      cyc_addr <= cyc_addr_nxt;
      lrdy_n   <= lrdy_n_nxt;
      dout_en  <= dout_en_nxt;
      wr_en    <= wr_en_nxt;
      if (wdat_ce) wr_data <= wdata;
    end
  end

  assign dout    = dout_en ? rd_data : '0;
  assign wr_addr = cyc_addr;

endmodule

// File: rtl/lbt_target_chk.sv
module lbt_target_chk #(
  parameter int unsigned AW = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ads_n,
  input logic [AW-1:0]     addr,
  input logic              mio,
  input logic              wr,
  input logic              fast_wr_ok,
  input logic              rdyrtn_n,
  input logic              claim_n,
  input logic              lrdy_n,
  input logic              dout_en,
  input logic              wr_en,
  input lbt_pkg::lbt_state_e st,
  input logic              cyc_wr
);
  import lbt_pkg::*;

  assert_claim_comb_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(addr) && $stable(mio) && $stable(wr)) |-> $stable(claim_n));

  assert_no_fast_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !ads_n && !wr) |=> lrdy_n);

  assert_no_fast_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !ads_n && wr && !fast_wr_ok) |=> lrdy_n);

  assert_ready_one_clock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !lrdy_n |=> lrdy_n);

  assert_data_before_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!lrdy_n && !cyc_wr) |-> dout_en);

  assert_hold_until_rtn_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && rdyrtn_n) |=> dout_en);

  assert_release_after_rtn_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_en && !rdyrtn_n && (st == ST_ACK || st == ST_HOLD)) |=> !dout_en);

  assert_write_after_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(!lrdy_n));

endmodule

bind lbt_target lbt_target_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ads_n      (ads_n),
  .addr       (addr),
  .mio        (mio),
  .wr         (wr),
  .fast_wr_ok (fast_wr_ok),
  .rdyrtn_n   (rdyrtn_n),
  .claim_n    (claim_n),
  .lrdy_n     (lrdy_n),
  .dout_en    (dout_en),
  .wr_en      (wr_en),
  .st         (st),
  .cyc_wr     (cyc_wr)
);

// File: tb/sim_lbt_target.sv
module sim_lbt_target;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ads_n, mio, wr, fast_wr_ok, hi_speed, late_dec, rdyrtn_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rd_data;
  logic          claim_n, lrdy_n, dout_en, wr_en;
  logic [DW-1:0] dout, wr_data;
  logic [AW-1:0] wr_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lbt_target u0 (
    .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .addr(addr), .mio(mio), .wr(wr),
    .fast_wr_ok(fast_wr_ok), .hi_speed(hi_speed), .late_dec(late_dec),
    .rdyrtn_n(rdyrtn_n), .wdata(wdata), .rd_data(rd_data), .claim_n(claim_n),
    .lrdy_n(lrdy_n), .dout(dout), .dout_en(dout_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] addr_pick(input int i);
    case (i)
      0: return 20'h003C0;
      1: return 20'h003CF;
      2: return 20'h003D0;
      3: return 20'h003BF;
      4: return 20'hC0000;
      5: return 20'hC7FFF;
      default: return 20'hC8000;
    endcase
  endfunction

  task automatic run_cycle(input logic [AW-1:0] a, input bit m, input bit w, input bit f,
                           input bit hs, input bit lt, input int r, input int seed);
    bit is_reg, is_rom, claimed;
    int wt, d, mn, last;
    is_reg  = (a >= 20'h003C0) && (a <= 20'h003CF) && !m;
    is_rom  = (a >= 20'hC0000) && (a <= 20'hC7FFF) && m && !w;
    claimed = is_reg || is_rom;
    wt = is_rom ? (2 + int'(hs)) : 0;   // R5: strap only affects ROM
    d  = int'(lt) + wt;                 // R4, R6
    mn = (!w || !f) ? 1 : 0;            // R2, R3
    if (d < mn) d = mn;
    last = claimed ? d + r + 2 : 5;

    @(negedge clk);
    addr = a; mio = m; wr = w; fast_wr_ok = f; hi_speed = hs; late_dec = lt;
    wdata = DW'(16'h1000 + seed); rd_data = DW'(16'hA000 + seed);
    rdyrtn_n = 1'b1;
    #1;
    chk(claim_n == !claimed, "R1 claim before strobe", claim_n, !claimed);
    ads_n = 1'b0;
    #1;
    chk(claim_n == !claimed, "R1 claim independent of strobe", claim_n, !claimed);
    @(posedge clk);
    for (int j = 0; j <= last; j++) begin
      bit e_rdy, e_oe, e_we;
      @(negedge clk);
      ads_n = 1'b1;
      e_rdy = claimed && (j == d);
      e_oe  = claimed && !w && (j >= 1) && (j <= d + r);
      e_we  = claimed && w && (j == d + 1);
      chk(lrdy_n == !e_rdy, claimed ? "R4 R7 ready clock" : "R11 no ready", lrdy_n, !e_rdy);
      chk(dout_en == e_oe, claimed ? "R8 R9 driver enable" : "R11 no enable", dout_en, e_oe);
      chk(dout == (e_oe ? rd_data : '0), "R8 read data", dout, e_oe ? rd_data : '0);
      chk(wr_en == e_we, claimed ? "R10 write strobe" : "R11 no write", wr_en, e_we);
      if (e_we) begin
        chk(wr_data == wdata, "R10 write data", wr_data, wdata);
        chk(wr_addr == a, "R10 write addr", wr_addr, a);
      end
      if (j == 0 && claimed && (!w || !f))
        chk(lrdy_n == 1'b1, w ? "R3 no first-T2 write ready" : "R2 no first-T2 read ready", lrdy_n, 1);
      if (j == 0 && claimed && w && f && !lt)
        chk(lrdy_n == 1'b0, "R3 zero-wait write", lrdy_n, 0);
      rdyrtn_n = !(claimed && !w && (j == d + r));
    end
    @(negedge clk);
    rdyrtn_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; ads_n = 1'b1; addr = '0; mio = 1'b0; wr = 1'b0;
    fast_wr_ok = 1'b0; hi_speed = 1'b0; late_dec = 1'b0; rdyrtn_n = 1'b1;
    wdata = '0; rd_data = 16'h5A5A;
    repeat (3) @(negedge clk);
    chk(lrdy_n == 1'b1, "R7 reset ready high", lrdy_n, 1);
    chk(dout_en == 1'b0, "R8 reset enable low", dout_en, 0);
    chk(wr_en == 1'b0, "R10 reset write low", wr_en, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: memory 0x3C0 not claimed, I/O 0x3C0 claimed, with no clock edge between
    addr = 20'h003C0; mio = 1'b1; wr = 1'b0; #1;
    chk(claim_n == 1'b1, "R1 memory 0x3C0 unclaimed", claim_n, 1);
    mio = 1'b0; #1;
    chk(claim_n == 1'b0, "R1 io 0x3C0 claimed", claim_n, 0);
    addr = 20'hC0000; mio = 1'b1; wr = 1'b1; #1;
    chk(claim_n == 1'b1, "R1 ROM write unclaimed", claim_n, 1);

    begin
      int seed = 0;
      for (int ai = 0; ai < 7; ai++)
        for (int m = 0; m < 2; m++)
          for (int w = 0; w < 2; w++)
            for (int f = 0; f < 2; f++)
              for (int hs = 0; hs < 2; hs++)
                for (int lt = 0; lt < 2; lt++)
                  for (int r = 0; r < 2; r++) begin
                    run_cycle(addr_pick(ai), m[0], w[0], f[0], hs[0], lt[0], r, seed);
                    seed++;
                  end
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule